// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer Core

This block is a 32-bit up-counting timer that runs on a single functional clock. One control word starts and stops it and sets every mode. Those modes cover reload on wrap, an optional power-of-two prescaler, a compare unit, capture of an input edge, and an output pin that reacts to timer events with a pulse or a toggle. Software reaches the timer through a plain word-addressed register port. Writes take effect at the clock edge. Reads return data combinationally.

Three status flags record match, overflow and capture events. Software clears each flag by writing a one to it. Two separate masks pick which flags drive the interrupt line and which drive the wakeup line. The counter can be written directly to preload it before a start. Writing the trigger address copies the load value into the counter, which begins a fresh period.

Register word addresses are: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 capture (read-only), 6 status, 7 interrupt mask, 8 wakeup mask.

Top module: `gpt_core`

## Requirements
- R1: After reset, the control, counter, load, match, capture, status and both mask registers read 0, and `tmr_out`, `irq` and `wake` are low.
- R2: While control bit 0 is set and the prescaler is off, the counter advances by one on every clock. While bit 0 is clear, the counter holds its value.
- R3: When control bit 5 is set, the counter advances once every 2^(v+1) clocks, where v is the value in control bits 4:2.
- R4: When the counter wraps from all-ones with control bit 1 set, it takes the load value and sets status bit 1.
- R5: When the counter wraps from all-ones with control bit 1 clear, it becomes 0, control bit 0 clears, and the counter stays at 0.
- R6: Any write to address 3 copies the load register into the counter at that clock edge.
- R7: A write to address 1 sets the counter directly, and reading address 1 returns the counter value.
- R8: With control bit 6 set, status bit 0 sets in the cycle the counter steps onto the match value. With bit 6 clear, no match is flagged.
- R9: Control bits 9:8 select the capture edge of `cap_in`: 00 none, 01 rising, 10 falling, 11 both. A selected edge copies the counter into the capture register three clocks after the pin changes and sets status bit 2.
- R10: With control bit 13 set, no new capture happens while status bit 2 is still set.
- R11: Writing 1 to a status bit clears it. `irq` is high when any status bit with its interrupt-mask bit set is high. `wake` does the same through the wakeup mask.
- R12: Control bits 11:10 select what drives the output: 00 nothing, 01 overflow only, 10 or 11 overflow and match. Control bit 7 is the idle level. In pulse mode (bit 12 clear) the output leaves the idle level for one clock per event. In toggle mode (bit 12 set) it inverts on every event.
- R13: With control bit 14 set, `tmr_out` stays at the idle level whatever the events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer event output pin |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
The counter is tested in four ways: free running, divided by the prescaler at two settings, and started just below all-ones both with and without reload. These cases separate an off-by-one in the divider from a wrong wrap rule. The capture input is driven with rising edges, falling edges and both edges under each edge setting. This shows whether edge detection and the hold-first rule behave as specified. The output pin is tested with overflow-only and overflow-plus-match sources, both idle levels, pulse and toggle styles, and the pin override. Together these confirm that each event reaches the pin only when its source is selected.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 4;
  localparam int CTRL_W = 15;

  // control bit positions (decoded by the counter, capture and output logic)
  localparam int C_START = 0;
  localparam int C_AREL  = 1;
  localparam int C_PV_LO = 2;
  localparam int C_PRE   = 5;
  localparam int C_CMP   = 6;
  localparam int C_IDLE  = 7;
  localparam int C_CE_LO = 8;
  localparam int C_TS_LO = 10;
  localparam int C_TOG   = 12;
  localparam int C_HOLD  = 13;
  localparam int C_PIN   = 14;

  // status bit positions
  localparam int ST_MAT = 0;
  localparam int ST_OVF = 1;
  localparam int ST_CAP = 2;
  localparam int ST_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_COUNT = 4'd1,
    A_LOAD  = 4'd2,
    A_TRIG  = 4'd3,
    A_MATCH = 4'd4,
    A_CAPT  = 4'd5,
    A_STAT  = 4'd6,
    A_IEN   = 4'd7,
    A_WEN   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PV_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pre_en,
  input  logic [PV_W-1:0] pre_val,
  output logic            tick
);
  localparam int PC_W = 2 ** PV_W;

  logic [PC_W-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    mask   = PC_W'((32'd2 << pre_val) - 32'd1);
    pcnt_d = run ? pcnt_q + 1'b1 : '0;
    tick   = run & (~pre_en | ((pcnt_q & mask) == mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/gpt_capsync.sv
module gpt_capsync #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       edge_evt
);
  logic [SYNC:0] sh_q, sh_d;
  logic          now_v, was_v;

  always_comb begin
    sh_d     = {sh_q[SYNC-1:0], pin};
    now_v    = sh_q[SYNC-1];
    was_v    = sh_q[SYNC];
    edge_evt = (sel[0] & now_v & ~was_v) | (sel[1] & ~now_v & was_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/gpt_outgen.sv
module gpt_outgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       mat_evt,
  input  logic [1:0] src_sel,
  input  logic       toggle,
  input  logic       idle_lvl,
  input  logic       pin_force,
  output logic       pin_out
);
  logic evt, pulse_q, pulse_d, tog_q, tog_d;

  always_comb begin
    unique case (src_sel)
      2'b00:   evt = 1'b0;
      2'b01:   evt = ovf_evt;
      default: evt = ovf_evt | mat_evt;
    endcase
    pulse_d = evt;
    tog_d   = (src_sel == 2'b00) ? 1'b0 : (tog_q ^ evt);
    pin_out = pin_force ? idle_lvl : (idle_lvl ^ (toggle ? tog_q : pulse_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      tog_q   <= tog_d;
    end
  end
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PV_W  = 3,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  output logic              tmr_out,
  output logic              irq,
  output logic              wake
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_run, load_q, load_d, match_q, match_d, capt_q, capt_d;
  logic [ST_W-1:0]   stat_q, stat_d, ien_q, ien_d, wen_q, wen_d, stat_clr;
  logic              tick, ovf, mat, edge_evt, cap_ok;

  gpt_prescale #(.PV_W(PV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[C_START]), .pre_en(ctrl_q[C_PRE]),
    .pre_val(ctrl_q[C_PV_LO +: PV_W]), .tick(tick));

  gpt_capsync #(.SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .sel(ctrl_q[C_CE_LO +: 2]),
    .edge_evt(edge_evt));

  gpt_outgen u_out (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf), .mat_evt(mat),
    .src_sel(ctrl_q[C_TS_LO +: 2]), .toggle(ctrl_q[C_TOG]),
    .idle_lvl(ctrl_q[C_IDLE]), .pin_force(ctrl_q[C_PIN]), .pin_out(tmr_out));

  always_comb begin
    ctrl_d   = ctrl_q;
    load_d   = load_q;
    match_d  = match_q;
    ien_d    = ien_q;
    wen_d    = wen_q;
    ovf      = 1'b0;
    cnt_run  = cnt_q;
    stat_clr = '0;

    if (tick) begin
      if (cnt_q == CNT_MAX) begin
        ovf = 1'b1;
        if (ctrl_q[C_AREL]) cnt_run = load_q;
        else begin
          cnt_run = '0;
          ctrl_d[C_START] = 1'b0;
        end
      end else begin
        cnt_run = cnt_q + 1'b1;
      end
    end
    mat    = tick & ctrl_q[C_CMP] & (cnt_run == match_q);
    cap_ok = edge_evt & ~(ctrl_q[C_HOLD] & stat_q[ST_CAP]);
    capt_d = cap_ok ? cnt_q : capt_q;
    cnt_d  = cnt_run;

    if (reg_we) begin
      unique case (reg_addr)
        A_CTRL:  ctrl_d   = reg_wdata[CTRL_W-1:0];
        A_COUNT: cnt_d    = reg_wdata;
        A_LOAD:  load_d   = reg_wdata;
        A_TRIG:  cnt_d    = load_q;
        A_MATCH: match_d  = reg_wdata;
        A_STAT:  stat_clr = reg_wdata[ST_W-1:0];
        A_IEN:   ien_d    = reg_wdata[ST_W-1:0];
        A_WEN:   wen_d    = reg_wdata[ST_W-1:0];
        default: ;
      endcase
    end

    stat_d = (stat_q & ~stat_clr) | {cap_ok, ovf, mat};

    unique case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_COUNT: reg_rdata = cnt_q;
      A_LOAD:  reg_rdata = load_q;
      A_MATCH: reg_rdata = match_q;
      A_CAPT:  reg_rdata = capt_q;
      A_STAT:  reg_rdata = CNT_W'(stat_q);
      A_IEN:   reg_rdata = CNT_W'(ien_q);
      A_WEN:   reg_rdata = CNT_W'(wen_q);
      default: reg_rdata = '0;
    endcase

    irq  = |(stat_q & ien_q);
    wake = |(stat_q & wen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      capt_q  <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cnt_q   <= cnt_d;
      load_q  <= load_d;
      match_q <= match_d;
      capt_q  <= capt_d;
      stat_q  <= stat_d;
      ien_q   <= ien_d;
      wen_q   <= wen_d;
    end
  end
endmodule

// File: rtl/gpt_core_chk.sv
module gpt_core_chk
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [ST_W-1:0]   wr_clr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [ST_W-1:0]   stat_q,
  input logic              tmr_out
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[C_START] && !reg_we) |=> $stable(cnt_q)); // R2

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_START] && ctrl_q[C_AREL] && !ctrl_q[C_PRE] && cnt_q == ALL1 && !reg_we)
    |=> (cnt_q == $past(load_q)) && stat_q[ST_OVF]); // R4

  AST_WRAP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_START] && !ctrl_q[C_AREL] && !ctrl_q[C_PRE] && cnt_q == ALL1 && !reg_we)
    |=> (cnt_q == '0) && !ctrl_q[C_START]); // R5

  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_TRIG) |=> cnt_q == $past(load_q)); // R6

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STAT && wr_clr == 3'b111 && !ctrl_q[C_START]
     && ctrl_q[C_CE_LO +: 2] == 2'b00) |=> stat_q == '0); // R11

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_PIN] |-> tmr_out == ctrl_q[C_IDLE]); // R13
endmodule

bind gpt_core gpt_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wr_clr(reg_wdata[2:0]), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .load_q(load_q),
  .stat_q(stat_q), .tmr_out(tmr_out));

// File: tb/sim_gpt_core.sv
`timescale 1ns/1ps
module sim_gpt_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        cap_in, tmr_out, irq, wake;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  gpt_core u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq), .wake(wake));

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input [3:0] a, input [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input [3:0] a, output [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(a[3:0], v); chk("R1 reg after reset", v, 0);
    end
    chk("R1 out/irq/wake", {29'd0, tmr_out, irq, wake}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(0, 0); wr(1, 100); wr(0, 1);
    waitn(7); rd(1, v); chk("R2 free count", v, 107);
    wr(0, 0); waitn(5); rd(1, v); chk("R2 hold when stopped", v, 109);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(0, 0); wr(1, 0); wr(0, 32'h25);
    waitn(3); rd(1, v); chk("R3 div4 before", v, 0);
    waitn(1); rd(1, v); chk("R3 div4 first", v, 1);
    waitn(4); rd(1, v); chk("R3 div4 second", v, 2);
    wr(0, 0); wr(1, 0); wr(0, 32'h29);
    waitn(7); rd(1, v); chk("R3 div8 before", v, 0);
    waitn(1); rd(1, v); chk("R3 div8 first", v, 1);
    wr(0, 0);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(6, 7); wr(1, 32'hFFFF_FFFD); wr(2, 32'h10); wr(0, 3);
    waitn(3); rd(1, v); chk("R4 reload value", v, 32'h10);
    rd(6, v); chk("R4 overflow flag", v & 2, 2);
    waitn(2); rd(1, v); chk("R4 counts on", v, 32'h12);
    wr(0, 0); wr(6, 7); wr(1, 32'hFFFF_FFFE); wr(0, 1);
    waitn(2); rd(1, v); chk("R5 wrap to zero", v, 0);
    rd(0, v); chk("R5 start cleared", v & 1, 0);
    waitn(3); rd(1, v); chk("R5 stays zero", v, 0);
    wr(6, 7);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    wr(0, 0); wr(2, 32'hABC); wr(1, 5);
    rd(1, v); chk("R7 direct write", v, 5);
    wr(3, 0); rd(1, v); chk("R6 trigger loads", v, 32'hABC);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(0, 0); wr(6, 7); wr(4, 5); wr(1, 0); wr(0, 32'h41);
    waitn(4); rd(6, v); chk("R8 not yet", v & 1, 0);
    waitn(1); rd(6, v); chk("R8 match flag", v & 1, 1);
    wr(0, 0); wr(6, 7); wr(1, 0); wr(0, 1);
    waitn(8); rd(6, v); chk("R8 compare off", v & 1, 0);
    wr(0, 0); wr(6, 7);
  endtask

  task automatic t_output();
    wr(0, 0); wr(2, 0); wr(1, 32'hFFFF_FFFF); wr(0, 32'h403);
    chk("R12 pulse idle", tmr_out, 0);
    waitn(1); chk("R12 overflow pulse", tmr_out, 1);
    waitn(1); chk("R12 pulse ends", tmr_out, 0);
    wr(0, 0); wr(4, 3); wr(1, 0); wr(0, 32'h841);
    waitn(2); chk("R12 match pre", tmr_out, 0);
    waitn(1); chk("R12 match pulse", tmr_out, 1);
    waitn(1); chk("R12 match pulse ends", tmr_out, 0);
    wr(0, 0); wr(1, 0); wr(0, 32'h441);
    for (int i = 0; i < 5; i++) begin
      waitn(1); chk("R12 match ignored on src01", tmr_out, 0);
    end
    wr(0, 0); wr(2, 32'hFFFF_FFFE); wr(1, 32'hFFFF_FFFF); wr(0, 32'h1403);
    chk("R12 toggle start", tmr_out, 0);
    waitn(1); chk("R12 toggle 1", tmr_out, 1);
    waitn(1); chk("R12 toggle hold", tmr_out, 1);
    waitn(1); chk("R12 toggle 2", tmr_out, 0);
    wr(0, 0); wr(2, 0); wr(1, 32'hFFFF_FFFF); wr(0, 32'h483);
    chk("R12 idle high", tmr_out, 1);
    waitn(1); chk("R12 pulse low", tmr_out, 0);
    waitn(1); chk("R12 back high", tmr_out, 1);
    wr(0, 0); wr(1, 32'hFFFF_FFFF); wr(0, 32'h4403);
    chk("R13 forced idle", tmr_out, 0);
    waitn(1); chk("R13 no pulse", tmr_out, 0);
    wr(0, 0); wr(6, 7);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    wr(0, 0); wr(6, 7); wr(1, 32'h1234); wr(0, 32'h100);
    cap_in = 1'b1;
    waitn(2); rd(6, v); chk("R9 not yet", v & 4, 0);
    waitn(1); rd(5, v); chk("R9 rising capture", v, 32'h1234);
    rd(6, v); chk("R9 capture flag", v & 4, 4);
    wr(1, 32'h2222); cap_in = 1'b0;
    waitn(4); rd(5, v); chk("R9 falling ignored", v, 32'h1234);
    wr(0, 32'h300); cap_in = 1'b1;
    waitn(3); rd(5, v); chk("R9 both edges", v, 32'h2222);
    wr(0, 32'h200); wr(1, 32'h3333); wr(6, 7); cap_in = 1'b0;
    waitn(3); rd(5, v); chk("R9 falling capture", v, 32'h3333);
    wr(0, 32'h2300); wr(1, 32'h4444); cap_in = 1'b1;
    waitn(4); rd(5, v); chk("R10 held while pending", v, 32'h3333);
    wr(6, 4); cap_in = 1'b0;
    waitn(3); rd(5, v); chk("R10 capture after clear", v, 32'h4444);
    wr(0, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    rd(6, v); chk("R11 capture pending", v, 4);
    chk("R11 no irq unmasked", {30'd0, irq, wake}, 0);
    wr(7, 4); chk("R11 irq on", {30'd0, irq, wake}, 2);
    wr(8, 4); chk("R11 wake on", {30'd0, irq, wake}, 3);
    wr(7, 1); chk("R11 irq masked", {30'd0, irq, wake}, 1);
    wr(6, 4); chk("R11 w1c clears", {30'd0, irq, wake}, 0);
    rd(6, v); chk("R11 status zero", v, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    waitn(1);
    t_reset();
    t_count();
    t_prescale();
    t_reload();
    t_trigger();
    t_match();
    t_output();
    t_capture();
    t_irq();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule